// File: doc/BRIEF.md
# E1 receive channel timing generator

This block produces the per-timeslot timing strobes that accompany an E1 receive serial stream. It counts bit positions within a 256-bit frame, made of 32 channels of 8 bits each with the most significant bit first. It also counts frames within a 16-frame multiframe. From these counts it drives three outputs. The first is a strobe on the last bit of every channel. The second is a gating level that covers whole channels and is chosen per timeslot by a 32-bit mask. The third is a one-clock sync pulse on frame or multiframe boundaries.

The block runs on the receive bit clock and has an active-low asynchronous reset. Upstream framing logic pulses `frame_align` for one clock to mark the start of a frame. It can also pulse `mf_align` together with `frame_align` to mark the start of a multiframe. All outputs are registered. The output state for bit position p appears in the clock cycle that follows the edge that entered position p.

Top module: `e1rx_chan_timing`

## Requirements
- R1: During reset, and after reset until the first `frame_align` pulse, `chan_lsb`, `chan_blk` and `sync_pulse` are all low.
- R2: When `frame_align` is high at a rising edge, the next cycle is bit 0 of channel 0. Positions then advance one per clock: 8 bits per channel, channels 0 to 31, so a frame lasts 256 clocks.
- R3: `chan_lsb` is high for exactly one clock, during bit 7 of every channel (frame bit count 8n+7). It is low at every other position.
- R4: `chan_blk` is high during all 8 bits of channel n when bit n of `chan_mask` is set, and low otherwise. Bit 0 of the mask belongs to channel 0.
- R5: `chan_mask` is sampled only at the edge that enters bit 0 of a channel. A change of the mask in the middle of a channel has no effect until the next channel starts.
- R6: With `sync_mode` = 0, `sync_pulse` is high for one clock during bit 0 of every frame.
- R7: With `sync_mode` = 1, `sync_pulse` is high only during bit 0 of frame 0. The frame count runs 0 to 15 and advances at every frame start, whether it comes from the natural wrap or from a realignment.
- R8: The first `frame_align` after reset starts frame 0. `mf_align` high together with `frame_align` forces frame 0. `mf_align` without `frame_align` has no effect.
- R9: A `frame_align` pulse in the middle of a frame restarts the position at bit 0 of channel 0 on the next cycle. The mask is then sampled again for channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_align | input | 1 | One-clock pulse marking bit 0 of a frame |
| mf_align | input | 1 | Together with frame_align, marks frame 0 of a multiframe |
| sync_mode | input | 1 | 0: sync on every frame, 1: sync on multiframe start only |
| chan_mask | input | 32 | Per-channel gating mask, bit n for channel n |
| chan_lsb | output | 1 | High during the last bit of every channel |
| chan_blk | output | 1 | High during the channels selected by the mask |
| sync_pulse | output | 1 | One-clock frame or multiframe boundary pulse |

## Verification
A wrong bit-within-channel count shows up within 8 clocks as a misplaced `chan_lsb`. A wrong channel count shows up at the next channel boundary as a `chan_blk` level taken from the wrong mask bit, and as a sync pulse moved within 256 clocks. A wrong frame count is visible only in multiframe mode, through a missing or extra sync pulse, so it can stay hidden for up to 16 frames (4096 clocks). For this reason the bench compares every output on every clock against a behavioural model, and it runs at least two full multiframes.

// File: rtl/e1rx_pkg.sv
package e1rx_pkg;

   typedef enum logic {
      SYNC_EVERY_FRAME = 1'b0,
      SYNC_MULTIFRAME  = 1'b1
   } e1rx_sync_e;

   // counter width that is at least one bit
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/e1rx_pos_counter.sv
module e1rx_pos_counter #(
   parameter int unsigned BITS_PER_CH   = 8,
   parameter int unsigned CHANNELS      = 32,
   parameter int unsigned FRAMES_PER_MF = 16,
   parameter bit          HAS_MF_ALIGN  = 1'b1,
   localparam int unsigned BW = e1rx_pkg::cnt_width(BITS_PER_CH),
   localparam int unsigned CW = e1rx_pkg::cnt_width(CHANNELS),
   localparam int unsigned FW = e1rx_pkg::cnt_width(FRAMES_PER_MF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_align,
   input  logic          mf_align,
   output logic          run_q,
   output logic          run_d,
   output logic [BW-1:0] bit_d,
   output logic [CW-1:0] ch_d,
   output logic [FW-1:0] fr_d
);

   localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_CH - 1);
   localparam logic [CW-1:0] CH_LAST  = CW'(CHANNELS - 1);
   localparam logic [FW-1:0] FR_LAST  = FW'(FRAMES_PER_MF - 1);

   logic [BW-1:0] bit_q;
   logic [CW-1:0] ch_q;
   logic [FW-1:0] fr_q;
   logic [FW-1:0] fr_inc;
   logic          mf_hit;

   generate
      if (HAS_MF_ALIGN) begin : g_mf
         assign mf_hit = mf_align;
      end else begin : g_no_mf
         assign mf_hit = 1'b0;
      end
   endgenerate

   assign fr_inc = (fr_q == FR_LAST) ? '0 : fr_q + 1'b1;

   always_comb begin
      run_d = run_q;
      bit_d = bit_q;
      ch_d  = ch_q;
      fr_d  = fr_q;
      if (frame_align) begin
         run_d = 1'b1;
         bit_d = '0;
         ch_d  = '0;
         fr_d  = (!run_q || mf_hit) ? '0 : fr_inc;
      end else if (run_q) begin
         if (bit_q == BIT_LAST) begin
            bit_d = '0;
            if (ch_q == CH_LAST) begin
               ch_d = '0;
               fr_d = fr_inc;
            end else begin
               ch_d = ch_q + 1'b1;
            end
         end else begin
            bit_d = bit_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         bit_q <= '0;
         ch_q  <= '0;
         fr_q  <= '0;
      end else begin
         run_q <= run_d;
         bit_q <= bit_d;
         ch_q  <= ch_d;
         fr_q  <= fr_d;
      end
   end

endmodule

// File: rtl/e1rx_mask_gate.sv
module e1rx_mask_gate #(
   parameter int unsigned CHANNELS = 32,
   localparam int unsigned CW = e1rx_pkg::cnt_width(CHANNELS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_d,
   input  logic                ch_start,
   input  logic [CW-1:0]       ch_d,
   input  logic [CHANNELS-1:0] chan_mask,
   output logic                chan_blk
);

   // mask bit is taken only when a channel begins, so the level holds for the whole channel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_blk <= 1'b0;
      end else if (!run_d) begin
         chan_blk <= 1'b0;
      end else if (ch_start) begin
         chan_blk <= chan_mask[ch_d];
      end
   end

endmodule

// File: rtl/e1rx_strobe_gen.sv
module e1rx_strobe_gen #(
   parameter int unsigned BITS_PER_CH   = 8,
   parameter int unsigned CHANNELS      = 32,
   parameter int unsigned FRAMES_PER_MF = 16,
   localparam int unsigned BW = e1rx_pkg::cnt_width(BITS_PER_CH),
   localparam int unsigned CW = e1rx_pkg::cnt_width(CHANNELS),
   localparam int unsigned FW = e1rx_pkg::cnt_width(FRAMES_PER_MF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_d,
   input  logic [BW-1:0] bit_d,
   input  logic [CW-1:0] ch_d,
   input  logic [FW-1:0] fr_d,
   input  logic          sync_mode,
   output logic          chan_lsb,
   output logic          sync_pulse
);

   import e1rx_pkg::*;

   localparam logic [BW-1:0] BIT_LAST = BW'(BITS_PER_CH - 1);

   logic       frame_start;
   logic       sync_hit;
   e1rx_sync_e mode;

   assign mode        = e1rx_sync_e'(sync_mode);
   assign frame_start = run_d && (bit_d == '0) && (ch_d == '0);

   always_comb begin
      unique case (mode)
         SYNC_MULTIFRAME:  sync_hit = frame_start && (fr_d == '0);
         default:          sync_hit = frame_start;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_lsb   <= 1'b0;
         sync_pulse <= 1'b0;
      end else begin
         chan_lsb   <= run_d && (bit_d == BIT_LAST);
         sync_pulse <= sync_hit;
      end
   end

endmodule

// File: rtl/e1rx_chan_timing.sv
module e1rx_chan_timing #(
   parameter int unsigned BITS_PER_CH   = 8,
   parameter int unsigned CHANNELS      = 32,
   parameter int unsigned FRAMES_PER_MF = 16,
   parameter bit          HAS_MF_ALIGN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_align,
   input  logic                mf_align,
   input  logic                sync_mode,
   input  logic [CHANNELS-1:0] chan_mask,
   output logic                chan_lsb,
   output logic                chan_blk,
   output logic                sync_pulse
);

   localparam int unsigned BW = e1rx_pkg::cnt_width(BITS_PER_CH);
   localparam int unsigned CW = e1rx_pkg::cnt_width(CHANNELS);
   localparam int unsigned FW = e1rx_pkg::cnt_width(FRAMES_PER_MF);

   generate
      if (BITS_PER_CH < 2) begin : g_bad_bits
         $error("BITS_PER_CH must be at least 2");
      end
      if (CHANNELS < 2) begin : g_bad_ch
         $error("CHANNELS must be at least 2");
      end
      if (FRAMES_PER_MF < 1) begin : g_bad_fr
         $error("FRAMES_PER_MF must be at least 1");
      end
   endgenerate

   logic          run_q;
   logic          run_d;
   logic [BW-1:0] bit_d;
   logic [CW-1:0] ch_d;
   logic [FW-1:0] fr_d;

   e1rx_pos_counter #(
      .BITS_PER_CH  (BITS_PER_CH),
      .CHANNELS     (CHANNELS),
      .FRAMES_PER_MF(FRAMES_PER_MF),
      .HAS_MF_ALIGN (HAS_MF_ALIGN)
   ) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_align(frame_align),
      .mf_align   (mf_align),
      .run_q      (run_q),
      .run_d      (run_d),
      .bit_d      (bit_d),
      .ch_d       (ch_d),
      .fr_d       (fr_d)
   );

   e1rx_mask_gate #(
      .CHANNELS(CHANNELS)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_d    (run_d),
      .ch_start (bit_d == '0),
      .ch_d     (ch_d),
      .chan_mask(chan_mask),
      .chan_blk (chan_blk)
   );

   e1rx_strobe_gen #(
      .BITS_PER_CH  (BITS_PER_CH),
      .CHANNELS     (CHANNELS),
      .FRAMES_PER_MF(FRAMES_PER_MF)
   ) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_d     (run_d),
      .bit_d     (bit_d),
      .ch_d      (ch_d),
      .fr_d      (fr_d),
      .sync_mode (sync_mode),
      .chan_lsb  (chan_lsb),
      .sync_pulse(sync_pulse)
   );

endmodule

// File: rtl/e1rx_chan_timing_chk.sv
module e1rx_chan_timing_chk #(
   parameter bit HAS_MF_ALIGN = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic frame_align,
   input logic mf_align,
   input logic sync_mode,
   input logic run,
   input logic chan_lsb,
   input logic chan_blk,
   input logic sync_pulse
);

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!chan_lsb && !chan_blk && !sync_pulse)); // R1

   AST_LSB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_lsb |=> !chan_lsb); // R3

   AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_lsb && !frame_align) |=> $stable(chan_blk)); // R5

   AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pulse && !frame_align) |=> !sync_pulse); // R6

   AST_ALIGN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_align && !sync_mode) |=> (sync_pulse && !chan_lsb)); // R9

   generate
      if (HAS_MF_ALIGN) begin : g_mf_chk
         AST_MF_ALIGN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_align && mf_align) |=> sync_pulse); // R8
      end
   endgenerate

endmodule

bind e1rx_chan_timing e1rx_chan_timing_chk #(
   .HAS_MF_ALIGN(HAS_MF_ALIGN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_align(frame_align),
   .mf_align   (mf_align),
   .sync_mode  (sync_mode),
   .run        (run_q),
   .chan_lsb   (chan_lsb),
   .chan_blk   (chan_blk),
   .sync_pulse (sync_pulse)
);

// File: tb/tb_e1rx_chan_timing.sv
`timescale 1ns/1ps
module tb_e1rx_chan_timing;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_align = 1'b0;
   logic        mf_align = 1'b0;
   logic        sync_mode = 1'b0;
   logic [31:0] chan_mask = '0;
   logic        chan_lsb;
   logic        chan_blk;
   logic        sync_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   e1rx_chan_timing dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_align(frame_align),
      .mf_align   (mf_align),
      .sync_mode  (sync_mode),
      .chan_mask  (chan_mask),
      .chan_lsb   (chan_lsb),
      .chan_blk   (chan_blk),
      .sync_pulse (sync_pulse)
   );

   // behavioural reference: position counters as plain integers
   bit m_run;
   int m_bit, m_ch, m_fr;
   bit m_lsb, m_blk, m_sync;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_bit = 0; m_ch = 0; m_fr = 0;
         m_lsb = 0; m_blk = 0; m_sync = 0;
      end else begin
         if (frame_align) begin
            m_fr  = (!m_run || mf_align) ? 0 : (m_fr + 1) % 16;
            m_bit = 0;
            m_ch  = 0;
            m_run = 1;
         end else if (m_run) begin
            m_bit = m_bit + 1;
            if (m_bit == 8) begin
               m_bit = 0;
               m_ch  = m_ch + 1;
               if (m_ch == 32) begin
                  m_ch = 0;
                  m_fr = (m_fr + 1) % 16;
               end
            end
         end
         m_lsb  = m_run && (m_bit == 7);
         m_sync = m_run && (m_bit == 0) && (m_ch == 0) && (!sync_mode || (m_fr == 0));
         if (!m_run)            m_blk = 0;
         else if (m_bit == 0)   m_blk = chan_mask[m_ch];
      end
   end

   task automatic check(input bit act, input bit exp, input string req, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(chan_lsb,   m_lsb,  m_run ? "R3" : "R1", "chan_lsb");
         check(chan_blk,   m_blk,  m_run ? "R4" : "R1", "chan_blk");
         check(sync_pulse, m_sync, !m_run ? "R1" : (sync_mode ? "R7" : "R6"), "sync_pulse");
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_align(input bit with_mf);
      frame_align = 1'b1;
      mf_align    = with_mf;
      tick(1);
      frame_align = 1'b0;
      mf_align    = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int syncs;
      bit held;
      tick(3);
      // R1: outputs low in reset
      check(chan_lsb, 1'b0, "R1", "reset chan_lsb");
      check(chan_blk, 1'b0, "R1", "reset chan_blk");
      check(sync_pulse, 1'b0, "R1", "reset sync_pulse");
      rst_n = 1'b1;
      chan_mask = 32'hA5C3_0F81;
      tick(40);
      check(chan_lsb | chan_blk | sync_pulse, 1'b0, "R1", "idle before alignment");

      // R2: first alignment, lsb 7 clocks after bit 0, frame 256 clocks long
      pulse_align(1'b0);
      check(sync_pulse, 1'b1, "R2", "bit 0 after alignment");
      check(chan_blk, 1'b1, "R4", "channel 0 mask bit set");
      tick(7);
      check(chan_lsb, 1'b1, "R2", "lsb of channel 0 at bit 7");
      tick(249);
      check(sync_pulse, 1'b1, "R2", "next frame after 256 clocks");
      tick(600);

      // R5: mask change in mid-channel (channel 5, bit 3)
      pulse_align(1'b0);
      chan_mask = 32'h0000_0020;
      tick(43);
      chan_mask = 32'h0000_0040;
      held = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick(1);
         held = held & chan_blk;
      end
      check(held, 1'b1, "R5", "channel 5 level held after mid-channel change");
      tick(1);
      check(chan_blk, 1'b1, "R5", "channel 6 takes new mask");
      tick(300);

      // R9: realignment in mid-frame
      chan_mask = 32'h1234_5679;
      tick(77);
      pulse_align(1'b0);
      check(sync_pulse, 1'b1, "R9", "sync after mid-frame realignment");
      check(chan_blk, 1'b1, "R9", "channel 0 sampled anew");
      tick(300);

      // R7/R8: multiframe mode, two full multiframes
      sync_mode = 1'b1;
      chan_mask = 32'hFFFF_0000;
      pulse_align(1'b1);
      syncs = 0;
      for (int i = 0; i < 8192; i++) begin
         if (sync_pulse) syncs++;
         tick(1);
      end
      check(syncs == 2, 1'b1, "R7", "two multiframe syncs in 8192 clocks");

      // R8: mf_align alone has no effect
      tick(100);
      mf_align = 1'b1;
      tick(1);
      mf_align = 1'b0;
      check(sync_pulse, 1'b0, "R8", "mf_align alone gives no sync");
      tick(500);

      // R7: plain realignment advances frame count, no sync in multiframe mode
      pulse_align(1'b0);
      check(sync_pulse, 1'b0, "R7", "realign without mf_align is not frame 0");
      tick(50);
      pulse_align(1'b1);
      check(sync_pulse, 1'b1, "R8", "mf_align with frame_align forces frame 0");
      tick(4200);

      // reset again mid-run
      rst_n = 1'b0;
      tick(2);
      check(chan_lsb | chan_blk | sync_pulse, 1'b0, "R1", "outputs low after second reset");
      rst_n = 1'b1;
      tick(20);
      check(chan_lsb | chan_blk | sync_pulse, 1'b0, "R1", "idle until new alignment");
      finish_run();
   end

endmodule